// File: doc/BRIEF.md
# Configurable Pad Drive Controller for an Eight-Pin I/O Bank

This block holds the output-mode logic for a bank of general-purpose pins. Each pin has a two-bit mode code and a port latch bit. From these the block derives five pad controls per pin: a strong pull-up, a weak pull-up, a very-weak pull-up, a pull-down and a combined output enable. The four modes are quasi-bidirectional, push-pull, input-only and open drain. In quasi-bidirectional mode the three pull-ups work as a graded set. The weak one follows the level read back from the pin. The strong one fires a short burst when the latch rises.

Software writes the latch bits or the mode codes through a single write port with a one-bit register select. A capability mask limits some pins to input-only or open drain, and a second mask pins one input permanently to input-only. The level on each pad is passed through a two-flop synchroniser. The result feeds the weak pull-up condition and is returned on a read-back port. The analog pad, its Schmitt input and any glitch filter lie outside the block.

Top module: `pin_drive_ctl`

## Requirements
- R1: After reset every mode field reads 10 (input-only), every latch bit reads 1, every drive output is low and the pin read-back is 0.
- R2: A write with `wr_addr`=1 loads the mode of pin i from `wr_data[2i+1:2i]`, where bit 2i+1 is the upper code bit. The codes are 00 quasi-bidirectional, 01 push-pull, 10 input-only and 11 open drain. `rd_mode` returns the stored codes in the same bit positions. A write with `wr_addr`=0 loads the latch of pin i from `wr_data[i]`.
- R3: In quasi-bidirectional mode `pu_vweak` equals the latch bit and `pd_en` equals its inverse. In every mode `oe` is high exactly when `pd_en` or `pu_strong` is high.
- R4: In quasi-bidirectional mode `pu_weak` is high only while the latch is 1 and the synchronised pin level is 1.
- R5: In quasi-bidirectional mode, a latch write that takes the bit from 0 to 1 raises `pu_strong` for exactly BURST_CLKS clocks (2 by default), starting in the cycle after the write edge. Rewriting a latch that is already 1 gives no burst, and the same write in open-drain mode gives no burst.
- R6: In push-pull mode `pu_strong` equals the latch, `pd_en` equals its inverse, `oe` is 1 and both weaker pull-ups are off.
- R7: In open-drain mode all three pull-ups are off, and `pd_en` and `oe` both equal the inverted latch.
- R8: In input-only mode all five drive outputs of the pin are low.
- R9: A pin in LIMITED_MASK (pins 2 and 3 by default) stores a requested 10 or 11 as written, and stores 10 when 00 or 01 is requested.
- R10: A pin in FIXED_IN_MASK (pin 5 by default) ignores mode writes and always reads 10.
- R11: A change on `pad_in` that is present before clock edge k appears on `rd_pin` and in the weak pull-up condition after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | 0 selects the latch bits, 1 selects the mode codes |
| wr_data | input | 2*NPIN | Write data |
| pad_in | input | NPIN | Raw pin levels from the pads |
| rd_mode | output | 2*NPIN | Stored mode codes |
| rd_latch | output | NPIN | Stored latch bits |
| rd_pin | output | NPIN | Synchronised pin levels |
| pu_strong | output | NPIN | Strong pull-up enable |
| pu_weak | output | NPIN | Weak pull-up enable |
| pu_vweak | output | NPIN | Very-weak pull-up enable |
| pd_en | output | NPIN | Pull-down enable |
| oe | output | NPIN | Any strong driver active |

## Verification
A corrupt mode register shows on `rd_mode` and in the drive pattern in the first cycle after the write that caused it. No later event is needed to expose it. A wrong burst counter shows as a strong pull-up that is one clock too long or too short, or that is missing, in the two cycles after a rising latch write. A wrong synchroniser depth moves the change on `rd_pin` and `pu_weak` one edge earlier or later than the second edge after the pad changes. The bench therefore samples each of these at the exact edge rather than after the outputs have settled.

// File: rtl/pin_drive_ctl.sv
module pin_drive_ctl #(
  parameter int              NPIN          = 8,
  parameter int              BURST_CLKS    = 2,
  parameter logic [NPIN-1:0] LIMITED_MASK  = 'h0C,
  parameter logic [NPIN-1:0] FIXED_IN_MASK = 'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [2*NPIN-1:0] wr_data,
  input  logic [NPIN-1:0]   pad_in,
  output logic [2*NPIN-1:0] rd_mode,
  output logic [NPIN-1:0]   rd_latch,
  output logic [NPIN-1:0]   rd_pin,
  output logic [NPIN-1:0]   pu_strong,
  output logic [NPIN-1:0]   pu_weak,
  output logic [NPIN-1:0]   pu_vweak,
  output logic [NPIN-1:0]   pd_en,
  output logic [NPIN-1:0]   oe
);
  localparam int CW = $clog2(BURST_CLKS + 1);
  localparam logic [1:0] M_QB = 2'b00, M_PP = 2'b01, M_IN = 2'b10, M_OD = 2'b11;

  logic [NPIN-1:0] lat_q, sync1_q, sync2_q;
  logic wr_lat, wr_mode;

  assign wr_lat   = wr_en & ~wr_addr;
  assign wr_mode  = wr_en &  wr_addr;
  assign rd_latch = lat_q;
  assign rd_pin   = sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q   <= '1;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      if (wr_lat) lat_q <= wr_data[NPIN-1:0];
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [1:0]    md_q, req;
    logic [CW-1:0] cnt_q;
    logic          qb, rise;

    assign req  = wr_data[2*g+1:2*g];
    assign qb   = (md_q == M_QB);
    assign rise = wr_lat & qb & ~lat_q[g] & wr_data[g];
    assign rd_mode[2*g+1:2*g] = md_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        md_q  <= M_IN;
        cnt_q <= '0;
      end else begin
        if (wr_mode && !FIXED_IN_MASK[g])
          md_q <= (LIMITED_MASK[g] && !req[1]) ? M_IN : req;
        if (rise)               cnt_q <= CW'(BURST_CLKS);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
      end
    end

    assign pu_vweak[g]  = qb & lat_q[g];
    assign pu_weak[g]   = qb & lat_q[g] & sync2_q[g];
    assign pu_strong[g] = lat_q[g] & ((qb & (cnt_q != '0)) | (md_q == M_PP));
    assign pd_en[g]     = ~lat_q[g] & (md_q != M_IN);
    assign oe[g]        = pd_en[g] | pu_strong[g];

    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= (pu_strong[g] && qb) ? run_q + (CW+1)'(1) : '0;
    end

    a_r5_burst_max: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= (CW+1)'(BURST_CLKS));
    a_r5_burst_start: assert property (@(posedge clk) disable iff (!rst_n)
      (qb && $past(qb) && !$past(lat_q[g]) && lat_q[g]) |-> pu_strong[g]);
    a_r4_weak_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
      pu_weak[g] |-> (pu_vweak[g] && rd_pin[g]));
    a_r7_od_no_pullup: assert property (@(posedge clk) disable iff (!rst_n)
      (md_q == M_OD) |-> !(pu_strong[g] || pu_weak[g] || pu_vweak[g]));
    a_r8_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (md_q == M_IN) |-> !(oe[g] || pd_en[g] || pu_strong[g] || pu_weak[g] || pu_vweak[g]));
    a_r6_pp_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (md_q == M_PP) |-> (oe[g] && (pu_strong[g] != pd_en[g])));

    if (LIMITED_MASK[g]) begin : g_lim
      a_r9_limited_modes: assert property (@(posedge clk) disable iff (!rst_n)
        md_q[1]);
    end
    if (FIXED_IN_MASK[g]) begin : g_fix
      a_r10_fixed_input: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (md_q == M_IN));
    end
  end
endmodule

// File: tb/test_pin_drive_ctl.sv
module test_pin_drive_ctl;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, wr_addr;
  logic [15:0] wr_data, rd_mode;
  logic [7:0]  pad_in, rd_latch, rd_pin, pu_strong, pu_weak, pu_vweak, pd_en, oe;
  int n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  pin_drive_ctl i_pin_drive_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pad_in(pad_in), .rd_mode(rd_mode), .rd_latch(rd_latch), .rd_pin(rd_pin),
    .pu_strong(pu_strong), .pu_weak(pu_weak), .pu_vweak(pu_vweak),
    .pd_en(pd_en), .oe(oe));

  typedef struct packed {
    logic [15:0] mode_req;
    logic [7:0]  latch;
    logic [7:0]  pad;
    logic [15:0] x_mode;
    logic [7:0]  x_strong, x_weak, x_vweak, x_pd, x_oe;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h5555, 8'hA5, 8'h00, 16'h59A5, 8'h81, 8'h00, 8'h00, 8'h52, 8'hD3},
    '{16'h0000, 8'hF0, 8'h30, 16'h08A0, 8'h00, 8'h10, 8'hD0, 8'h03, 8'h03},
    '{16'hFFFF, 8'h0F, 8'hFF, 16'hFBFF, 8'h00, 8'h00, 8'h00, 8'hD0, 8'hD0},
    '{16'hAAAA, 8'h00, 8'hFF, 16'hAAAA, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
    '{16'h7634, 8'h5B, 8'h01, 16'h7AB4, 8'h02, 8'h01, 8'h01, 8'h84, 8'h86}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", rd_mode, 16'hAAAA);
    chk("R1 latch", {8'h0, rd_latch}, 16'h00FF);
    chk("R1 drives", {pu_strong | pu_weak | pu_vweak, pd_en | oe}, 16'h0000);
    chk("R1 pin", {8'h0, rd_pin}, 16'h0000);

    foreach (VECS[k]) begin
      wr(1'b1, VECS[k].mode_req);
      wr(1'b0, {8'h00, VECS[k].latch});
      pad_in = VECS[k].pad;
      repeat (5) @(negedge clk);
      chk("R2 R9 R10 mode", rd_mode, VECS[k].x_mode);
      chk("R2 latch", {8'h0, rd_latch}, {8'h0, VECS[k].latch});
      chk("R5 R6 strong", {8'h0, pu_strong}, {8'h0, VECS[k].x_strong});
      chk("R4 weak", {8'h0, pu_weak}, {8'h0, VECS[k].x_weak});
      chk("R3 vweak", {8'h0, pu_vweak}, {8'h0, VECS[k].x_vweak});
      chk("R3 R6 R7 R8 pd", {8'h0, pd_en}, {8'h0, VECS[k].x_pd});
      chk("R3 R6 R7 R8 oe", {8'h0, oe}, {8'h0, VECS[k].x_oe});
      chk("R11 pin", {8'h0, rd_pin}, {8'h0, VECS[k].pad});
    end

    // R5: strong burst of two clocks after a rising latch write in quasi mode
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h0000);
    repeat (3) @(negedge clk);
    wr(1'b0, 16'h0001);
    chk("R5 burst c1", {8'h0, pu_strong}, 16'h0001);
    @(negedge clk);
    chk("R5 burst c2", {8'h0, pu_strong}, 16'h0001);
    @(negedge clk);
    chk("R5 burst end", {8'h0, pu_strong}, 16'h0000);
    wr(1'b0, 16'h0001);
    chk("R5 no burst on 1 to 1", {8'h0, pu_strong}, 16'h0000);

    // R5: open drain rising latch gives no burst
    wr(1'b1, 16'hFFFF);
    wr(1'b0, 16'h0000);
    wr(1'b0, 16'h0001);
    chk("R5 no burst open drain", {8'h0, pu_strong}, 16'h0000);

    // R11 / R4: two-flop read-back latency
    wr(1'b1, 16'h0000);
    wr(1'b0, 16'h00FF);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    pad_in = 8'h01;
    @(negedge clk);
    chk("R11 pin after one edge", {8'h0, rd_pin}, 16'h0000);
    chk("R4 weak after one edge", {8'h0, pu_weak}, 16'h0000);
    @(negedge clk);
    chk("R11 pin after two edges", {8'h0, rd_pin}, 16'h0001);
    chk("R4 weak after two edges", {8'h0, pu_weak}, 16'h0001);

    // R10: the fixed pin ignores a push-pull request
    wr(1'b1, 16'h0400);
    chk("R10 fixed pin mode", {14'h0, rd_mode[11:10]}, 16'h0002);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule